// File: doc/BRIEF.md
# Byte-Steering Read Port for a 12-Bit Conversion Result

This block sits between a finished 12-bit conversion result and a shared data bus of twelve lines. The bus is split into three 4-bit nibbles. Each nibble is driven through its own enable and data pair, which stands in for a tri-state pad. The block qualifies a read from four control inputs: a chip enable, an active-low chip select, a read/convert line and the busy flag from the conversion sequencer. A width select and a byte address then decide how the result is laid out. In word mode the whole result goes out at once. In byte mode an 8-bit host reads the eight upper bits first. It then reads the four lower bits, placed in the top nibble and followed by four zero bits, so that the value is left-justified.

A small state machine holds the layout that is currently driven. Its states are ST_IDLE (nothing driven), ST_WORD, ST_HBYTE (upper byte), ST_LBYTE (lower byte) and ST_GAP (nothing driven, between two layouts). The transitions are as follows:

- open: ST_IDLE to the selected layout, when the read becomes qualified.
- hold: a layout state stays in itself while the selection is unchanged.
- break: a layout state goes to ST_GAP when the selection changes.
- make: ST_GAP goes to the selected layout.
- close: any state goes to ST_IDLE when the read stops being qualified.

Because of this sequence, the upper-byte and lower-byte drivers are never on in the same cycle. For a plain stand-alone hookup, tie the chip enable and the width select high and tie the byte address and the chip select low. The result can then be read whenever the read/convert line is high and the block is not busy.

Top module: `byte_steer_rd`

## Requirements
- R1: If any read condition is false at a clock edge, which means rd_cnv low, busy high, chip_en low or chip_sel_n high, then after that edge nib_oe is 3'b000, bus_dq is zero, hi_byte_drv and lo_byte_drv are 0, and nib_zero is 0. This is also the state after reset.
- R2: From an undriven state, the selected layout is driven starting one clock edge after the edge at which all read conditions are true.
- R3: In word mode (word_mode=1), nib_oe is 3'b111, bus_dq equals result, hi_byte_drv is 1, and byte_addr has no effect.
- R4: In byte mode with byte_addr=0, nib_oe is 3'b110 (bit i enables bus_dq[4i+3:4i]), bus_dq[11:4] equals result[11:4], and hi_byte_drv is 1.
- R5: In byte mode with byte_addr=1, nib_oe is 3'b110, bus_dq[11:8] equals result[3:0], bus_dq[7:4] is forced to zero with nib_zero=1, and lo_byte_drv is 1 while hi_byte_drv is 0.
- R6: hi_byte_drv and lo_byte_drv are never 1 in the same cycle.
- R7: If the selected layout changes while the read stays qualified, there is exactly one cycle with every enable at 0 before the new layout is driven.
- R8: Any nibble whose enable is 0 drives zero on its four data lines.
- R9: With the stand-alone tie-offs, the full word follows rd_cnv and busy with the same one-edge latency.
- R10: A rising busy during a read turns every driver off after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | Read/convert line, high for read |
| byte_addr | input | 1 | Byte address: 0 selects the upper byte, 1 selects the lower byte |
| word_mode | input | 1 | 1 = full word, 0 = two-byte layout |
| busy | input | 1 | Conversion in progress, from the sequencer |
| result | input | 12 | Conversion result to present |
| nib_oe | output | 3 | Per-nibble output enable, bit i covers bus_dq[4i+3:4i] |
| nib_zero | output | 1 | Middle nibble zero override active |
| hi_byte_drv | output | 1 | Upper-byte/word driver group enabled |
| lo_byte_drv | output | 1 | Lower-byte driver group enabled |
| bus_dq | output | 12 | Data value presented to the pads |

## Verification
Every enable, flag and data value comes from the state register, so each response is due one clock edge after the inputs that caused it. The bench changes inputs just after a falling edge. A behavioural model advances on the rising edge from those same inputs. On the following falling edge every output is compared with the model, which places each sample exactly one edge after its stimulus. A layout change therefore shows up as a gap cycle at the first sample and as the new layout at the second. The model's integer state follows these rules independently of the design.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WORD  = 3'd1,
        ST_HBYTE = 3'd2,
        ST_LBYTE = 3'd3,
        ST_GAP   = 3'd4
    } rd_state_e;
endpackage

// File: rtl/bsr_qualify.sv
module bsr_qualify
    import bsr_pkg::*;
(
    input  logic      chip_en,
    input  logic      chip_sel_n,
    input  logic      rd_cnv,
    input  logic      busy,
    input  logic      word_mode,
    input  logic      byte_addr,
    output logic      ready,
    output rd_state_e target
);
    // All four read conditions must hold together.
    assign ready = rd_cnv & ~busy & chip_en & ~chip_sel_n;

    always_comb begin
        if (word_mode)      target = ST_WORD;
        else if (byte_addr) target = ST_LBYTE;
        else                target = ST_HBYTE;
    end
endmodule

// File: rtl/bsr_fsm.sv
module bsr_fsm
    import bsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ready,
    input  rd_state_e target,
    output rd_state_e state
);
    rd_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!ready) begin
            nxt = ST_IDLE;                                // close
        end else begin
            unique case (state)
                ST_IDLE, ST_GAP: nxt = target;            // open / make
                default:         nxt = (state == target) ? target   // hold
                                                         : ST_GAP;  // break
            endcase
        end
    end
endmodule

// File: rtl/bsr_lanes.sv
module bsr_lanes
    import bsr_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  rd_state_e             state,
    input  logic [3*NIB_W-1:0]    result,
    output logic [2:0]            nib_oe,
    output logic                  nib_zero,
    output logic                  hi_byte_drv,
    output logic                  lo_byte_drv,
    output logic [3*NIB_W-1:0]    bus_dq
);
    localparam int NIB_N = 3;
    localparam int TOP   = NIB_N - 1;

    always_comb begin
        nib_zero    = (state == ST_LBYTE);
        hi_byte_drv = (state == ST_WORD) || (state == ST_HBYTE);
        lo_byte_drv = (state == ST_LBYTE);
    end

    for (genvar i = 0; i < NIB_N; i++) begin : g_nib
        always_comb begin
            nib_oe[i]                   = 1'b0;
            bus_dq[i*NIB_W +: NIB_W]    = '0;
            unique case (state)
                ST_WORD: begin
                    nib_oe[i]                = 1'b1;
                    bus_dq[i*NIB_W +: NIB_W] = result[i*NIB_W +: NIB_W];
                end
                ST_HBYTE: begin
                    if (i != 0) begin
                        nib_oe[i]                = 1'b1;
                        bus_dq[i*NIB_W +: NIB_W] = result[i*NIB_W +: NIB_W];
                    end
                end
                ST_LBYTE: begin
                    if (i == TOP) begin
                        nib_oe[i]                = 1'b1;
                        bus_dq[i*NIB_W +: NIB_W] = result[NIB_W-1:0];
                    end else if (i != 0) begin
                        nib_oe[i]                = 1'b1;   // forced-zero nibble
                    end
                end
                default: begin
                    nib_oe[i]                = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/byte_steer_rd.sv
module byte_steer_rd
    import bsr_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_en,
    input  logic                 chip_sel_n,
    input  logic                 rd_cnv,
    input  logic                 byte_addr,
    input  logic                 word_mode,
    input  logic                 busy,
    input  logic [3*NIB_W-1:0]   result,
    output logic [2:0]           nib_oe,
    output logic                 nib_zero,
    output logic                 hi_byte_drv,
    output logic                 lo_byte_drv,
    output logic [3*NIB_W-1:0]   bus_dq
);
    logic      ready;
    rd_state_e target;
    rd_state_e state;

    bsr_qualify u_qual (
        .chip_en    (chip_en),
        .chip_sel_n (chip_sel_n),
        .rd_cnv     (rd_cnv),
        .busy       (busy),
        .word_mode  (word_mode),
        .byte_addr  (byte_addr),
        .ready      (ready),
        .target     (target)
    );

    bsr_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready  (ready),
        .target (target),
        .state  (state)
    );

    bsr_lanes #(.NIB_W(NIB_W)) u_lanes (
        .state       (state),
        .result      (result),
        .nib_oe      (nib_oe),
        .nib_zero    (nib_zero),
        .hi_byte_drv (hi_byte_drv),
        .lo_byte_drv (lo_byte_drv),
        .bus_dq      (bus_dq)
    );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int NIB_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chip_en,
    input logic                 chip_sel_n,
    input logic                 rd_cnv,
    input logic                 byte_addr,
    input logic                 word_mode,
    input logic                 busy,
    input logic [3*NIB_W-1:0]   result,
    input logic [2:0]           nib_oe,
    input logic                 nib_zero,
    input logic                 hi_byte_drv,
    input logic                 lo_byte_drv,
    input logic [3*NIB_W-1:0]   bus_dq
);
    localparam int DW = 3 * NIB_W;

    logic          rd_ok;
    logic [DW-1:0] live;

    assign rd_ok = rd_cnv && !busy && chip_en && !chip_sel_n;

    for (genvar i = 0; i < 3; i++) begin : g_live
        assign live[i*NIB_W +: NIB_W] = {NIB_W{nib_oe[i]}};
    end

    a_r1_dark_when_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> (nib_oe == 3'b000 && !hi_byte_drv && !lo_byte_drv && !nib_zero));

    a_r2_word_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && word_mode && nib_oe == 3'b000) |=> (nib_oe == 3'b111));

    a_r3_word_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && word_mode && nib_oe == 3'b111) |=> (bus_dq == result));

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_byte_drv && lo_byte_drv));

    a_r7_break_hi: assert property (@(posedge clk) disable iff (!rst_n)
        hi_byte_drv |=> (hi_byte_drv || !lo_byte_drv));

    a_r7_break_lo: assert property (@(posedge clk) disable iff (!rst_n)
        lo_byte_drv |=> (lo_byte_drv || !hi_byte_drv));

    a_r8_dark_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dq & ~live) == '0));

    a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (nib_oe == 3'b000));
endmodule

bind byte_steer_rd bsr_checker #(.NIB_W(NIB_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .chip_sel_n  (chip_sel_n),
    .rd_cnv      (rd_cnv),
    .byte_addr   (byte_addr),
    .word_mode   (word_mode),
    .busy        (busy),
    .result      (result),
    .nib_oe      (nib_oe),
    .nib_zero    (nib_zero),
    .hi_byte_drv (hi_byte_drv),
    .lo_byte_drv (lo_byte_drv),
    .bus_dq      (bus_dq)
);

// File: tb/byte_steer_rd_tb_top.sv
`timescale 1ns/1ps
module byte_steer_rd_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b0;
    logic        chip_sel_n = 1'b1;
    logic        rd_cnv = 1'b0;
    logic        byte_addr = 1'b0;
    logic        word_mode = 1'b1;
    logic        busy = 1'b0;
    logic [11:0] result = 12'h000;
    logic [2:0]  nib_oe;
    logic        nib_zero;
    logic        hi_byte_drv;
    logic        lo_byte_drv;
    logic [11:0] bus_dq;

    int errors = 0;
    int checks = 0;
    int m_st   = 0;   // 0 idle, 1 word, 2 upper byte, 3 lower byte, 4 gap
    string scen = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    byte_steer_rd dut_i (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
        .rd_cnv(rd_cnv), .byte_addr(byte_addr), .word_mode(word_mode), .busy(busy),
        .result(result), .nib_oe(nib_oe), .nib_zero(nib_zero),
        .hi_byte_drv(hi_byte_drv), .lo_byte_drv(lo_byte_drv), .bus_dq(bus_dq)
    );

    // Behavioural reference: next layout from the qualified-read rules.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_st <= 0;
        else begin
            automatic bit ok  = rd_cnv && !busy && chip_en && !chip_sel_n;
            automatic int tgt = word_mode ? 1 : (byte_addr ? 3 : 2);
            if (!ok)                                  m_st <= 0;
            else if (m_st == 0 || m_st == 4 || m_st == tgt) m_st <= tgt;
            else                                      m_st <= 4;
        end
    end

    function automatic string st_req(int s);
        case (s)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [11:0] e_dq;
        logic [2:0]  e_oe;
        string tag;
        tag = {st_req(m_st), "/", scen};
        case (m_st)
            1: begin e_dq = result;                    e_oe = 3'b111; end
            2: begin e_dq = {result[11:4], 4'h0};      e_oe = 3'b110; end
            3: begin e_dq = {result[3:0], 8'h00};      e_oe = 3'b110; end
            default: begin e_dq = 12'h000;             e_oe = 3'b000; end
        endcase
        chk(nib_oe == e_oe, {tag, " oe"}, 16'(nib_oe), 16'(e_oe));
        chk(bus_dq == e_dq, {tag, " data"}, 16'(bus_dq), 16'(e_dq));
        chk(hi_byte_drv == (m_st == 1 || m_st == 2), {tag, " hi_drv"},
            16'(hi_byte_drv), 16'(m_st == 1 || m_st == 2));
        chk(lo_byte_drv == (m_st == 3), {tag, " lo_drv"}, 16'(lo_byte_drv), 16'(m_st == 3));
        chk(nib_zero == (m_st == 3), {tag, " zero"}, 16'(nib_zero), 16'(m_st == 3));
        chk(!(hi_byte_drv && lo_byte_drv), "R6 overlap",
            16'({hi_byte_drv, lo_byte_drv}), 16'h0);
        for (int i = 0; i < 3; i++)
            if (!nib_oe[i])
                chk(bus_dq[i*4 +: 4] == 4'h0, "R8 dark nibble", 16'(bus_dq[i*4 +: 4]), 16'h0);
    endtask

    task automatic cyc(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic set_rd(bit en, bit csn, bit rc, bit bz);
        chip_en = en; chip_sel_n = csn; rd_cnv = rc; busy = bz;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(2);
        rst_n = 1'b1;
        cyc(2);

        // R1: each read condition false in turn
        result = 12'hA5C; word_mode = 1'b1;
        set_rd(1'b0, 1'b0, 1'b1, 1'b0); cyc(2);
        set_rd(1'b1, 1'b1, 1'b1, 1'b0); cyc(2);
        set_rd(1'b1, 1'b0, 1'b0, 1'b0); cyc(2);
        set_rd(1'b1, 1'b0, 1'b1, 1'b1); cyc(2);

        // R2: one-edge latency, then word data (R3)
        scen = "R2";
        set_rd(1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(nib_oe == 3'b111, "R2 latency", 16'(nib_oe), 16'h7);
        compare();
        scen = "R3";
        byte_addr = 1'b1; cyc(2);        // ignored in word mode
        result = 12'h3E7; cyc(1);
        byte_addr = 1'b0; result = 12'hFFF; cyc(2);

        // R7: word to upper byte passes a gap
        scen = "R7";
        word_mode = 1'b0; result = 12'hB61;
        @(negedge clk);
        chk(nib_oe == 3'b000, "R7 gap word->hi", 16'(nib_oe), 16'h0);
        compare();
        cyc(2);                           // R4 upper byte
        scen = "R5";
        byte_addr = 1'b1;
        @(negedge clk);
        chk(!hi_byte_drv && !lo_byte_drv, "R7 gap hi->lo",
            16'({hi_byte_drv, lo_byte_drv}), 16'h0);
        compare();
        cyc(2);                           // lower byte
        result = 12'h00F; cyc(1);
        byte_addr = 1'b0; cyc(3);         // back to upper byte via gap

        // R7: byte address toggling every cycle
        scen = "R7";
        for (int k = 0; k < 8; k++) begin
            byte_addr = ~byte_addr; result = 12'(k * 12'h135); cyc(1);
        end
        byte_addr = 1'b1; cyc(3);
        word_mode = 1'b1; cyc(3);         // lower byte -> gap -> word

        // R10: busy rises during a read
        scen = "R10";
        busy = 1'b1; cyc(2);
        busy = 1'b0; word_mode = 1'b0; byte_addr = 1'b1; result = 12'h9C4; cyc(3);
        busy = 1'b1; cyc(1);
        busy = 1'b0; cyc(2);

        // R9: stand-alone tie-offs, rd_cnv and busy moving
        scen = "R9";
        chip_en = 1'b1; word_mode = 1'b1; byte_addr = 1'b0; chip_sel_n = 1'b0;
        rd_cnv = 1'b0; busy = 1'b1; cyc(2);
        rd_cnv = 1'b1; cyc(2);            // still busy
        busy = 1'b0; result = 12'h7D2; cyc(3);
        rd_cnv = 1'b0; cyc(2);
        rd_cnv = 1'b1; result = 12'h001; cyc(2);

        // R1: deselect while a byte is driven
        scen = "R1";
        word_mode = 1'b0; cyc(3);
        chip_sel_n = 1'b1; cyc(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule